// File: doc/BRIEF.md
# Striped Vector Register Layout Mapper

This block translates between the byte order of a memory image and the striped byte layout used inside a group of vector registers. A register is divided into equal sections. Elements are packed into fixed 32-bit clusters: four 8-bit elements, two 16-bit elements or one 32-bit element per cluster. A 64-bit element takes one 8-byte slot of its own. Successive clusters or slots are dealt round-robin across the sections. Each section fills from its lowest byte upward. When a register is full, the next clusters continue into the next register of the group.

In the load direction the block scatters a contiguous memory image into the register layout. In the store direction it gathers the register layout back into memory order. Bytes whose element index is at or beyond the active vector length get a cleared write-enable bit and a zero data byte. The element width and the vector length may change on every cycle. The register width, the section width, the group size and the cluster size are fixed when the block is built. Results are registered, so they appear one clock after the inputs.

Top module: `stripe_layout_mapper`

## Requirements
- R1: While reset is asserted, and at the first clock after it, `dataOut` and `byteEn` are all zero.
- R2: Outputs are registered. A change at the inputs is not visible before the next rising clock edge, and it is visible after that edge.
- R3: `elemWidth` encodes the element size: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit. On a load (`loadSel` = 1) the memory bytes are cut into 4-byte clusters. Cluster k goes to section k mod S (S = register bytes / section bytes), at the next free cluster slot from the bottom of that section. Example: 128-bit sections, 8-bit elements, length 8: elements 0..3 land in bytes 0x00..0x03 and elements 4..7 in bytes 0x10..0x13.
- R4: With 128-bit sections and 32-bit elements, elements 0, 2, 4, 6 fill bytes 0x00..0x0F and elements 1, 3, 5, 7 fill bytes 0x10..0x1F.
- R5: With 128-bit sections and 16-bit elements, elements 0 and 1 take bytes 0x00..0x03, elements 4 and 5 take 0x04..0x07, elements 2 and 3 take 0x10..0x13, and elements 6 and 7 take 0x14..0x17.
- R6: 64-bit elements use 8-byte slots dealt the same way. Bytes 0x20..0x3F of the bus form the second register of the group. With 128-bit sections and length 8, the first register holds elements 0, 2, 1, 3 at offsets 0x00, 0x08, 0x10, 0x18, and the second register holds elements 4, 6, 5, 7 at the same offsets.
- R7: With 64-bit sections and length 13, 32-bit elements put elements k and k+4 in section k of the first register. In the second register they put element 8 at 0x20, element 12 at 0x24, element 9 at 0x28, element 10 at 0x30 and element 11 at 0x38. 8-bit elements put elements 0..3 at 0x00, 4..7 at 0x08, 8..11 at 0x10 and element 12 at 0x18.
- R8: When the section is as wide as the register, every element width yields plain contiguous memory order.
- R9: A store (`loadSel` = 0) applies the exact inverse of the load mapping, so a store of a load result returns the original memory bytes. On a store, `byteEn` is set exactly for memory bytes below length × element bytes, which forms a contiguous run from byte 0.
- R10: A byte whose element index is at or beyond `vecLen` has `byteEn` cleared and data zero. A length of 0 clears every enable. A length above the group's capacity enables every byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| loadSel | input | 1 | 1 = scatter memory order into register layout, 0 = gather register layout into memory order |
| elemWidth | input | 2 | Element width code (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits) |
| vecLen | input | 7 | Active number of elements |
| dataIn | input | 512 | Source bytes, byte i at bits 8i+7..8i |
| dataOut | output | 512 | Permuted bytes, registered |
| byteEn | output | 64 | Per-byte write enable, registered |

## Verification
Two functions meet in the same cycle: the position mapping and the length cutoff. An element that lands in the second register, or shares a section with unused slots, must be placed correctly while its neighbours are masked. Lengths such as 13 at 32-bit and 8-bit widths with 64-bit sections provoke this. Each landing byte is judged against positions worked out by hand, along with the enable bit of a byte just past the end. Load and store also meet back to back: a load result is fed straight into a store on the next cycle. The bench judges it by requiring the original memory image to return with a prefix enable mask, for every width and for full and partial lengths on three section widths.

// File: rtl/stripe_pkg.sv
package stripe_pkg;

  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } elemWidth_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       scatter;   // 1: memory order -> register layout
    logic [1:0] elemLog;   // log2 of element bytes
    logic [1:0] slotLog;   // log2 of slot bytes (cluster or element, whichever larger)
  } mapStrobe_t;

endpackage

// File: rtl/stripe_ctrl.sv
module stripe_ctrl
  import stripe_pkg::*;
#(
  parameter int CLUSTER_BITS = 32
) (
  input  logic       loadSel,
  input  logic [1:0] elemWidth,
  output mapStrobe_t strobes
);

  localparam int CB_LOG = $clog2(CLUSTER_BITS / 8);

  elemWidth_e ewCode;
  assign ewCode = elemWidth_e'(elemWidth);

  always_comb begin
    strobes.scatter = loadSel;
    strobes.elemLog = ewCode;
    // an element wider than a cluster occupies a slot of its own size
    if (int'(ewCode) > CB_LOG) strobes.slotLog = ewCode;
    else                       strobes.slotLog = 2'(CB_LOG);
  end

endmodule

// File: rtl/stripe_index_map.sv
module stripe_index_map #(
  parameter int VLEN         = 256,
  parameter int SLEN         = 128,
  parameter int GROUP        = 2,
  parameter int CLUSTER_BITS = 32,
  localparam int TB          = GROUP * VLEN / 8,
  localparam int IW          = $clog2(TB)
) (
  input  logic [1:0]    slotLog,
  output logic [IW-1:0] fwdIdx [TB],   // memory byte -> register byte
  output logic [IW-1:0] invIdx [TB]    // register byte -> memory byte
);

  localparam int VB_LOG = $clog2(VLEN / 8);
  localparam int SB_LOG = $clog2(SLEN / 8);
  localparam int NS_LOG = VB_LOG - SB_LOG;

  function automatic int toRegByte(int m, int sl);
    int slot, off, reg_, t, sec, pos;
    slot = m >> sl;
    off  = m & ((1 << sl) - 1);
    reg_ = slot >> (VB_LOG - sl);
    t    = slot & ((1 << (VB_LOG - sl)) - 1);
    sec  = t & ((1 << NS_LOG) - 1);
    pos  = t >> NS_LOG;
    return (reg_ << VB_LOG) | (sec << SB_LOG) | (pos << sl) | off;
  endfunction

  function automatic int toMemByte(int d, int sl);
    int reg_, w, sec, inSec, pos, off, t;
    reg_  = d >> VB_LOG;
    w     = d & ((1 << VB_LOG) - 1);
    sec   = w >> SB_LOG;
    inSec = w & ((1 << SB_LOG) - 1);
    pos   = inSec >> sl;
    off   = inSec & ((1 << sl) - 1);
    t     = (pos << NS_LOG) | sec;
    return ((((reg_ << (VB_LOG - sl)) | t) << sl) | off);
  endfunction

  for (genvar j = 0; j < TB; j++) begin : g_byte
    always_comb begin
      fwdIdx[j] = IW'(toRegByte(j, int'(slotLog)));
      invIdx[j] = IW'(toMemByte(j, int'(slotLog)));
    end
  end

  // the two directions must be exact inverses (R9)
  always_comb begin
    if (!$isunknown(slotLog)) begin
      for (int j = 0; j < TB; j++) begin
        assert_bijection_R9: assert (toMemByte(toRegByte(j, int'(slotLog)), int'(slotLog)) == j)
          else $error("mapping not invertible at byte %0d", j);
      end
    end
  end

endmodule

// File: rtl/stripe_datapath.sv
module stripe_datapath
  import stripe_pkg::*;
#(
  parameter int VLEN  = 256,
  parameter int GROUP = 2,
  localparam int TB   = GROUP * VLEN / 8,
  localparam int IW   = $clog2(TB),
  localparam int VLW  = $clog2(TB + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  mapStrobe_t      strobes,
  input  logic [VLW-1:0]  vecLen,
  input  logic [TB*8-1:0] dataIn,
  input  logic [IW-1:0]   fwdIdx [TB],
  input  logic [IW-1:0]   invIdx [TB],
  output logic [TB*8-1:0] dataOut,
  output logic [TB-1:0]   byteEn
);

  logic [TB*8-1:0] nextData;
  logic [TB-1:0]   nextEn;

  always_comb begin
    for (int j = 0; j < TB; j++) begin
      logic [IW-1:0] memIdx;
      logic [IW-1:0] pickIdx;
      int            elem;
      // memory byte that this output byte corresponds to
      memIdx  = strobes.scatter ? invIdx[j] : IW'(j);
      pickIdx = strobes.scatter ? invIdx[j] : fwdIdx[j];
      elem    = int'(memIdx) >> strobes.elemLog;
      nextEn[j] = (elem < int'(vecLen));
      nextData[j*8 +: 8] = nextEn[j] ? dataIn[int'(pickIdx)*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      byteEn  <= '0;
    end else begin
      dataOut <= nextData;
      byteEn  <= nextEn;
    end
  end

  // ---------------- assertions ----------------
  logic [IW:0] expectCount;
  always_comb begin
    int raw;
    raw = int'(vecLen) << strobes.elemLog;
    expectCount = (raw > TB) ? (IW+1)'(TB) : (IW+1)'(raw);
  end

  assert_live_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ($countones(byteEn) == int'($past(expectCount))))
    else $error("enabled byte count wrong");

  assert_empty_len_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && vecLen == '0) |=> (byteEn == '0))
    else $error("zero length left bytes enabled");

  assert_store_prefix_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !strobes.scatter) |=> ((byteEn & (byteEn + 1'b1)) == '0))
    else $error("store enable mask not a prefix");

  for (genvar j = 0; j < TB; j++) begin : g_zero
    assert_inactive_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
      !byteEn[j] |-> (dataOut[j*8 +: 8] == 8'h00))
      else $error("disabled byte %0d carries data", j);
  end

endmodule

// File: rtl/stripe_layout_mapper.sv
module stripe_layout_mapper
  import stripe_pkg::*;
#(
  parameter int VLEN         = 256,
  parameter int SLEN         = 128,
  parameter int GROUP        = 2,
  parameter int CLUSTER_BITS = 32,
  localparam int TB          = GROUP * VLEN / 8,
  localparam int VLW         = $clog2(TB + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            loadSel,
  input  logic [1:0]      elemWidth,
  input  logic [VLW-1:0]  vecLen,
  input  logic [TB*8-1:0] dataIn,
  output logic [TB*8-1:0] dataOut,
  output logic [TB-1:0]   byteEn
);

  localparam int IW = $clog2(TB);

  mapStrobe_t    strobes;
  logic [IW-1:0] fwdIdx [TB];
  logic [IW-1:0] invIdx [TB];

  stripe_ctrl #(
    .CLUSTER_BITS(CLUSTER_BITS)
  ) u_ctrl (
    .loadSel  (loadSel),
    .elemWidth(elemWidth),
    .strobes  (strobes)
  );

  stripe_index_map #(
    .VLEN        (VLEN),
    .SLEN        (SLEN),
    .GROUP       (GROUP),
    .CLUSTER_BITS(CLUSTER_BITS)
  ) u_map (
    .slotLog(strobes.slotLog),
    .fwdIdx (fwdIdx),
    .invIdx (invIdx)
  );

  stripe_datapath #(
    .VLEN (VLEN),
    .GROUP(GROUP)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .vecLen (vecLen),
    .dataIn (dataIn),
    .fwdIdx (fwdIdx),
    .invIdx (invIdx),
    .dataOut(dataOut),
    .byteEn (byteEn)
  );

endmodule

// File: tb/stripe_layout_mapper_bench.sv
module stripe_layout_mapper_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         loadSel = 1'b1;
  logic [1:0]   elemWidth = 2'd0;
  logic [6:0]   vecLen = 7'd0;
  logic [511:0] dataIn = '0;
  logic [511:0] dOut [3];
  logic [63:0]  mOut [3];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  // dut 0: 128-bit sections, dut 1: 64-bit sections, dut 2: 256-bit sections
  stripe_layout_mapper #(.SLEN(128)) u_stripe_layout_mapper (
    .clk(clk), .rstN(rstN), .loadSel(loadSel), .elemWidth(elemWidth),
    .vecLen(vecLen), .dataIn(dataIn), .dataOut(dOut[0]), .byteEn(mOut[0]));
  stripe_layout_mapper #(.SLEN(64)) u_stripe_layout_mapper_s64 (
    .clk(clk), .rstN(rstN), .loadSel(loadSel), .elemWidth(elemWidth),
    .vecLen(vecLen), .dataIn(dataIn), .dataOut(dOut[1]), .byteEn(mOut[1]));
  stripe_layout_mapper #(.SLEN(256)) u_stripe_layout_mapper_s256 (
    .clk(clk), .rstN(rstN), .loadSel(loadSel), .elemWidth(elemWidth),
    .vecLen(vecLen), .dataIn(dataIn), .dataOut(dOut[2]), .byteEn(mOut[2]));

  typedef struct packed {
    logic [1:0] dut;
    logic [1:0] ew;
    logic [6:0] vl;
    logic [5:0] idx;
    logic [7:0] val;   // expected byte; 0 means disabled
    logic [3:0] req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t TBL [NV] = '{
    // R3: 128-bit sections, 8-bit, length 8
    '{2'd0, 2'd0, 7'd8,  6'h00, 8'd1,  4'd3},
    '{2'd0, 2'd0, 7'd8,  6'h03, 8'd4,  4'd3},
    '{2'd0, 2'd0, 7'd8,  6'h10, 8'd5,  4'd3},
    '{2'd0, 2'd0, 7'd8,  6'h13, 8'd8,  4'd3},
    '{2'd0, 2'd0, 7'd8,  6'h04, 8'd0,  4'd10},
    // R4: 32-bit
    '{2'd0, 2'd2, 7'd8,  6'h10, 8'd5,  4'd4},
    '{2'd0, 2'd2, 7'd8,  6'h04, 8'd9,  4'd4},
    '{2'd0, 2'd2, 7'd8,  6'h1C, 8'd29, 4'd4},
    '{2'd0, 2'd2, 7'd8,  6'h0C, 8'd25, 4'd4},
    // R5: 16-bit
    '{2'd0, 2'd1, 7'd8,  6'h04, 8'd9,  4'd5},
    '{2'd0, 2'd1, 7'd8,  6'h10, 8'd5,  4'd5},
    '{2'd0, 2'd1, 7'd8,  6'h17, 8'd16, 4'd5},
    '{2'd0, 2'd1, 7'd8,  6'h02, 8'd3,  4'd5},
    // R6: 64-bit over two registers
    '{2'd0, 2'd3, 7'd8,  6'h08, 8'd17, 4'd6},
    '{2'd0, 2'd3, 7'd8,  6'h10, 8'd9,  4'd6},
    '{2'd0, 2'd3, 7'd8,  6'h20, 8'd33, 4'd6},
    '{2'd0, 2'd3, 7'd8,  6'h28, 8'd49, 4'd6},
    '{2'd0, 2'd3, 7'd8,  6'h38, 8'd57, 4'd6},
    '{2'd0, 2'd3, 7'd8,  6'h3F, 8'd64, 4'd6},
    // R7: 64-bit sections, 32-bit, length 13
    '{2'd1, 2'd2, 7'd13, 6'h20, 8'd33, 4'd7},
    '{2'd1, 2'd2, 7'd13, 6'h24, 8'd49, 4'd7},
    '{2'd1, 2'd2, 7'd13, 6'h28, 8'd37, 4'd7},
    '{2'd1, 2'd2, 7'd13, 6'h30, 8'd41, 4'd7},
    '{2'd1, 2'd2, 7'd13, 6'h38, 8'd45, 4'd7},
    '{2'd1, 2'd2, 7'd13, 6'h08, 8'd5,  4'd7},
    '{2'd1, 2'd2, 7'd13, 6'h0C, 8'd21, 4'd7},
    '{2'd1, 2'd2, 7'd13, 6'h2C, 8'd0,  4'd10},
    // R7: 64-bit sections, 8-bit, length 13
    '{2'd1, 2'd0, 7'd13, 6'h08, 8'd5,  4'd7},
    '{2'd1, 2'd0, 7'd13, 6'h10, 8'd9,  4'd7},
    '{2'd1, 2'd0, 7'd13, 6'h18, 8'd13, 4'd7},
    '{2'd1, 2'd0, 7'd13, 6'h0B, 8'd8,  4'd7},
    '{2'd1, 2'd0, 7'd13, 6'h19, 8'd0,  4'd10},
    // R8: section equals register
    '{2'd2, 2'd2, 7'd8,  6'h10, 8'd17, 4'd8},
    '{2'd2, 2'd2, 7'd8,  6'h1F, 8'd32, 4'd8},
    '{2'd2, 2'd1, 7'd3,  6'h05, 8'd6,  4'd8},
    '{2'd2, 2'd1, 7'd3,  6'h06, 8'd0,  4'd10}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [511:0] memPattern();
    logic [511:0] p;
    for (int m = 0; m < 64; m++) p[m*8 +: 8] = 8'(m + 1);
    return p;
  endfunction

  // drive at a falling edge, then sample at the next falling edge
  task automatic apply(input bit ld, input int ew, input int vl, input logic [511:0] d);
    @(negedge clk);
    loadSel   = ld;
    elemWidth = 2'(ew);
    vecLen    = 7'(vl);
    dataIn    = d;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset with active inputs
    loadSel = 1'b1; elemWidth = 2'd0; vecLen = 7'd64; dataIn = memPattern();
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++)
      check(dOut[k] == '0 && mOut[k] == '0, "R1 outputs zero in reset", mOut[k], 64'h0);
    rstN = 1'b1;

    // table walk: R3..R8, R10
    for (int i = 0; i < NV; i++) begin
      vec_t e;
      logic [7:0] gotV;
      logic       gotM;
      e = TBL[i];
      apply(1'b1, int'(e.ew), int'(e.vl), memPattern());
      gotV = dOut[e.dut][int'(e.idx)*8 +: 8];
      gotM = mOut[e.dut][e.idx];
      check(gotV == e.val && gotM == (e.val != 8'd0),
            $sformatf("R%0d table entry %0d byte %0h", e.req, i, e.idx),
            {55'd0, gotM, gotV}, {55'd0, (e.val != 8'd0), e.val});
    end

    // R2: new inputs invisible before the edge, visible after it
    apply(1'b1, 0, 64, memPattern());
    @(negedge clk);
    loadSel = 1'b1; elemWidth = 2'd2; vecLen = 7'd0; dataIn = '0;
    #1;
    check(mOut[0] == 64'hFFFF_FFFF_FFFF_FFFF, "R2 holds before edge", mOut[0], 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    check(mOut[0] == 64'h0, "R2 updates after edge", mOut[0], 64'h0);

    // R10: zero length and over-capacity length
    apply(1'b1, 3, 0, memPattern());
    check(mOut[1] == 64'h0 && dOut[1] == '0, "R10 zero length", mOut[1], 64'h0);
    apply(1'b1, 3, 100, memPattern());
    check(mOut[0] == 64'hFFFF_FFFF_FFFF_FFFF, "R10 over capacity", mOut[0], 64'hFFFF_FFFF_FFFF_FFFF);

    // R9: load then store round trip, all widths, full and partial lengths
    for (int k = 0; k < 3; k++) begin
      for (int ew = 0; ew < 4; ew++) begin
        for (int pass = 0; pass < 2; pass++) begin
          int vl, nb, bad;
          logic [511:0] regImg;
          logic [63:0]  expM;
          logic [7:0]   expB, gotB;
          vl = (pass == 0) ? 127 : 13;
          nb = ((vl << ew) > 64) ? 64 : (vl << ew);
          apply(1'b1, ew, vl, memPattern());
          regImg = dOut[k];
          apply(1'b0, ew, vl, regImg);
          expM = (nb == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << nb) - 64'd1);
          bad = -1;
          for (int m = 63; m >= 0; m--) begin
            logic [7:0] want;
            want = (m < nb) ? 8'(m + 1) : 8'h00;
            if (dOut[k][m*8 +: 8] != want) bad = m;
          end
          expB = 8'h00; gotB = 8'h00;
          if (bad >= 0) begin
            expB = (bad < nb) ? 8'(bad + 1) : 8'h00;
            gotB = dOut[k][bad*8 +: 8];
          end
          check(bad < 0, $sformatf("R9 round trip dut %0d ew %0d vl %0d", k, ew, vl),
                {56'd0, gotB}, {56'd0, expB});
          check(mOut[k] == expM, $sformatf("R9 store mask dut %0d ew %0d vl %0d", k, ew, vl),
                mOut[k], expM);
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule